// File: doc/BRIEF.md
# Interleaved Channel Subset Selector

This block sits on a time-multiplexed sample stream in which every frame carries a fixed number of channels, one gated word per cycle, in channel order. A frame trigger input, high in the idle gap between frames, closes the current frame. A keep mask chooses which channel positions are forwarded. Each word is tagged with its position in the frame. Words whose mask bit is set leave the block one cycle later with an output gate. Unselected words produce no output gate. The data register holds its last selected value in between.

The trigger is delayed by the same single register stage as the data, so frame edges stay aligned downstream. A frame is any run of gated words that ends in a trigger cycle. If that run is not empty and its length differs from the channel count, a timing-error pulse appears together with the delayed trigger. A parameter selects whether channel 0 is the most or the least significant mask bit.

Top module: `chan_subset_sel`

## Requirements
- R1: The channel count NCH is a parameter (default 12) and the data width DW a parameter (default 16). Input and output data have the same width. A frame of exactly NCH gated words raises no error.
- R2: With LSB_FIRST=0, channel i is enabled by keep_mask[NCH-1-i], so the MSB is channel 0. With LSB_FIRST=1, channel i is enabled by keep_mask[i].
- R3: The channel index is 0 in the cycle after any trigger cycle. It advances by one for each gated word in a non-trigger cycle.
- R4: out_gate is high in the cycle after a gated input word whose channel index is below NCH and whose mask bit is set. In that same cycle, out_data equals that word. Otherwise out_gate is low.
- R5: While out_gate is low, out_data keeps its previous value.
- R6: out_trig equals in_trig delayed by exactly one clock.
- R7: time_err is high for one cycle, in the cycle after a trigger cycle, when the number of gated words since the previous trigger cycle is non-zero and not equal to NCH. A gated word in the trigger cycle itself is included in that count.
- R8: A gated word that arrives in the same cycle as the trigger belongs to the closing frame. It is selected or dropped by that frame's current index, and the next frame starts at channel 0.
- R9: Gated words beyond the NCH-th word of a frame never raise out_gate.
- R10: Reset is synchronous and active low. After a clock with rst_n low, out_gate, out_trig and time_err are 0, out_data is 0 and the channel index is 0. Inputs present during reset are ignored.
- R11: Trigger cycles with no gated word since the previous trigger, such as consecutive idle trigger cycles, raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DW | Multiplexed sample word |
| in_gate | input | 1 | Word valid |
| in_trig | input | 1 | Frame close / idle marker |
| keep_mask | input | NCH | Per-channel keep bits, order set by LSB_FIRST |
| out_data | output | DW | Last selected word |
| out_gate | output | 1 | Selected word valid |
| out_trig | output | 1 | Trigger delayed to match data |
| time_err | output | 1 | Frame length mismatch pulse |

## Verification
A gated word and a frame trigger can land in the same cycle. That one cycle then has to decide the word's selection with the old index, count the word toward the closing frame's length, and restart the index. Table entries end frames with the trigger raised on their last word, with lengths that make the count come out exactly NCH, one short and one long. The bench judges the cycle by out_gate and out_data for that last word, by time_err on the following cycle, and by whether the next frame's first word is treated as channel 0.

// File: rtl/chan_subset_pkg.sv
// Package: shared helpers for the channel subset selector.
// Assumes: channel counts are small positive integers.
package chan_subset_pkg;

    // Index width able to hold 0..NCH+1 (NCH+1 marks "over length").
    function automatic int idx_width(input int nch);
        return $clog2(nch + 2);
    endfunction

endpackage

// File: rtl/chan_subset_order.sv
// Module: chan_subset_order
// Maps the keep mask onto a vector whose bit i enables channel i.
// Assumes: LSB_FIRST selects the bit order; purely combinational.
module chan_subset_order #(
    parameter int NCH       = 12,
    parameter bit LSB_FIRST = 1'b0
) (
    input  logic [NCH-1:0] keep_mask,
    output logic [NCH-1:0] chan_en
);

    generate
        if (LSB_FIRST) begin : g_lsb
            // Channel i taken straight from bit i.
            assign chan_en = keep_mask;
        end else begin : g_msb
            for (genvar i = 0; i < NCH; i++) begin : g_bit
                // Channel i taken from the mirrored bit position.
                assign chan_en[i] = keep_mask[NCH-1-i];
            end
        end
    endgenerate

endmodule

// File: rtl/chan_subset_count.sv
// Module: chan_subset_count
// Tracks the channel position within a frame and judges frame length
// when the trigger closes it.
// Assumes: a gate in a trigger cycle belongs to the closing frame; the
// index saturates at NCH+1 so long frames stay distinguishable.
module chan_subset_count #(
    parameter int NCH = 12,
    parameter int IW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_gate,
    input  logic          in_trig,
    output logic [IW-1:0] idx,
    output logic          frame_bad
);

    localparam logic [IW-1:0] FULL = IW'(NCH);
    localparam logic [IW-1:0] CAP  = IW'(NCH + 1);

    logic [IW-1:0] bumped;

    // Frame length including the current word, saturated at CAP.
    always_comb begin
        if (!in_gate)        bumped = idx;
        else if (idx == CAP) bumped = CAP;
        else                 bumped = idx + IW'(1);
    end

    // A closing trigger with a non-empty, wrong-length frame is bad.
    assign frame_bad = in_trig && (bumped != '0) && (bumped != FULL);

    // Channel position register: restart on trigger, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (in_trig) idx <= '0;
        else              idx <= bumped;
    end

endmodule

// File: rtl/chan_subset_emit.sv
// Module: chan_subset_emit
// Output register stage: data, gate, trigger and error share one stage
// so all leave the block with the same latency.
// Assumes: sel is already qualified by gate, index and mask.
module chan_subset_emit #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [DW-1:0] in_data,
    input  logic          in_trig,
    input  logic          frame_bad,
    output logic [DW-1:0] out_data,
    output logic          out_gate,
    output logic          out_trig,
    output logic          time_err
);

    // Control outputs: one-cycle delayed flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_gate <= 1'b0;
            out_trig <= 1'b0;
            time_err <= 1'b0;
        end else begin
            out_gate <= sel;
            out_trig <= in_trig;
            time_err <= frame_bad;
        end
    end

    // Data register: loads only selected words, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   out_data <= '0;
        else if (sel) out_data <= in_data;
    end

endmodule

// File: rtl/chan_subset_sel.sv
// Module: chan_subset_sel (top)
// Forwards the mask-selected channels of a frame-interleaved stream,
// with a delayed frame trigger and a frame-length error pulse.
// Assumes: channels arrive in order 0..NCH-1 after each trigger.
module chan_subset_sel #(
    parameter int NCH       = 12,
    parameter int DW        = 16,
    parameter bit LSB_FIRST = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  in_data,
    input  logic           in_gate,
    input  logic           in_trig,
    input  logic [NCH-1:0] keep_mask,
    output logic [DW-1:0]  out_data,
    output logic           out_gate,
    output logic           out_trig,
    output logic           time_err
);

    localparam int IW = chan_subset_pkg::idx_width(NCH);
    localparam int EW = 2 ** IW;

    logic [NCH-1:0] chan_en;
    logic [EW-1:0]  en_ext;
    logic [IW-1:0]  idx_q;
    logic           frame_bad;
    logic           sel;

    chan_subset_order #(.NCH(NCH), .LSB_FIRST(LSB_FIRST)) i_order (
        .keep_mask (keep_mask),
        .chan_en   (chan_en)
    );

    chan_subset_count #(.NCH(NCH), .IW(IW)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_gate   (in_gate),
        .in_trig   (in_trig),
        .idx       (idx_q),
        .frame_bad (frame_bad)
    );

    // Zero-extend so indices at or past NCH read a disabled bit.
    assign en_ext = EW'(chan_en);

    // Word is kept when gated and its position is enabled.
    assign sel = in_gate && en_ext[idx_q];

    chan_subset_emit #(.DW(DW)) i_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .in_data   (in_data),
        .in_trig   (in_trig),
        .frame_bad (frame_bad),
        .out_data  (out_data),
        .out_gate  (out_gate),
        .out_trig  (out_trig),
        .time_err  (time_err)
    );

endmodule

// File: rtl/chan_subset_chk.sv
// Module: chan_subset_chk
// Temporal checks on the selector's ports and channel index.
// Assumes: bound to every chan_subset_sel instance.
module chan_subset_chk #(
    parameter int NCH = 12,
    parameter int DW  = 16,
    parameter int IW  = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_gate,
    input logic          in_trig,
    input logic [DW-1:0] out_data,
    input logic          out_gate,
    input logic          out_trig,
    input logic          time_err,
    input logic [IW-1:0] idx
);

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_gate && !out_trig && !time_err && idx == '0));

    p_trig_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_trig |=> out_trig);

    p_trig_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_trig |=> !out_trig);

    p_gate_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_gate |=> !out_gate);

    p_err_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        time_err |-> out_trig);

    p_idx_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_trig |=> (idx == '0));

    p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gate && !in_trig && idx < IW'(NCH)) |=> (idx == $past(idx) + IW'(1)));

    p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_gate && $past(rst_n)) |-> $stable(out_data));

endmodule

bind chan_subset_sel chan_subset_chk #(.NCH(NCH), .DW(DW), .IW(IW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_gate  (in_gate),
    .in_trig  (in_trig),
    .out_data (out_data),
    .out_gate (out_gate),
    .out_trig (out_trig),
    .time_err (time_err),
    .idx      (idx_q)
);

// File: tb/test_chan_subset_sel.sv
// Bench: drives a table of frames into two selectors (MSB-first and
// LSB-first mask order) and checks every cycle against a bench model,
// then runs directed reset tests.
module test_chan_subset_sel;

    localparam int NCH = 12;
    localparam int DW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [DW-1:0]  in_data = '0;
    logic           in_gate = 1'b0;
    logic           in_trig = 1'b0;
    logic [NCH-1:0] keep = '0;
    logic [DW-1:0]  od_m, od_l;
    logic           og_m, og_l, ot_m, ot_l, te_m, te_l;

    int checks = 0;
    int errors = 0;

    // Bench model state.
    int            bidx = 0;
    logic [DW-1:0] exp_dm = '0;
    logic [DW-1:0] exp_dl = '0;

    always #5 clk = ~clk;

    chan_subset_sel #(.NCH(NCH), .DW(DW), .LSB_FIRST(1'b0)) i_chan_subset_sel (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_gate(in_gate),
        .in_trig(in_trig), .keep_mask(keep), .out_data(od_m), .out_gate(og_m),
        .out_trig(ot_m), .time_err(te_m));

    chan_subset_sel #(.NCH(NCH), .DW(DW), .LSB_FIRST(1'b1)) i_chan_subset_sel_lsb (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_gate(in_gate),
        .in_trig(in_trig), .keep_mask(keep), .out_data(od_l), .out_gate(og_l),
        .out_trig(ot_l), .time_err(te_l));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, model, check after the posedge.
    task automatic step(input logic g, input logic t, input logic [DW-1:0] d);
        logic sm, sl, err;
        int   len;
        @(negedge clk);
        in_gate = g; in_trig = t; in_data = d;
        sm  = g && (bidx < NCH) && keep[NCH-1-((bidx < NCH) ? bidx : 0)];
        sl  = g && (bidx < NCH) && keep[(bidx < NCH) ? bidx : 0];
        len = bidx + (g ? 1 : 0);
        err = t && (len != 0) && (len != NCH);
        if (sm) exp_dm = d;
        if (sl) exp_dl = d;
        bidx = t ? 0 : ((len > NCH + 1) ? NCH + 1 : len);
        @(posedge clk); #1;
        chk("R4/R2 gate msb-first", 32'(og_m), 32'(sm));
        chk("R5 data msb-first", 32'(od_m), 32'(exp_dm));
        chk("R2 gate lsb-first", 32'(og_l), 32'(sl));
        chk("R5 data lsb-first", 32'(od_l), 32'(exp_dl));
        chk("R6 trig delay", 32'({ot_m, ot_l}), 32'({t, t}));
        chk("R7 time_err", 32'({te_m, te_l}), 32'({err, err}));
    endtask

    task automatic do_reset(input logic g, input logic t);
        @(negedge clk);
        rst_n = 1'b0; in_gate = g; in_trig = t; in_data = 16'hDEAD;
        @(posedge clk); #1;
        chk("R10 gate after reset", 32'({og_m, og_l}), 32'd0);
        chk("R10 trig after reset", 32'({ot_m, ot_l}), 32'd0);
        chk("R10 err after reset", 32'({te_m, te_l}), 32'd0);
        chk("R10 data after reset", 32'({od_m, od_l}), 32'd0);
        bidx = 0; exp_dm = '0; exp_dl = '0;
        @(negedge clk);
        rst_n = 1'b1; in_gate = 1'b0; in_trig = 1'b1;
    endtask

    // Frame table: {mask, word count, trigger on last word}.
    localparam int NV = 9;
    localparam logic [17:0] VEC [NV] = '{
        {12'hFFF, 5'd12, 1'b0},  // R1 full frame, no error
        {12'h000, 5'd12, 1'b0},  // R4 nothing kept
        {12'hA5C, 5'd12, 1'b0},  // R2 mixed mask, order differs
        {12'h801, 5'd12, 1'b1},  // R8 trigger on 12th word, no error
        {12'h3F0, 5'd10, 1'b0},  // R7 short frame
        {12'hFFF, 5'd14, 1'b0},  // R9 long frame, extra words dropped
        {12'h0F3, 5'd11, 1'b1},  // R8 11 words incl. trigger word: error
        {12'hC03, 5'd13, 1'b1},  // R8/R9 13 words incl. trigger word
        {12'h555, 5'd12, 1'b0}   // R3 index restart after prior frames
    };

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0, 1'b0);
        step(1'b0, 1'b1, '0);   // R11 idle trigger cycles
        step(1'b0, 1'b1, '0);
        for (int v = 0; v < NV; v++) begin
            keep = VEC[v][17:6];
            for (int s = 0; s < int'(VEC[v][5:1]); s++)
                step(1'b1, VEC[v][0] && (s == int'(VEC[v][5:1]) - 1),
                     DW'(v * 256 + s + 1));
            step(1'b0, 1'b1, '0);
            step(1'b0, 1'b1, '0);  // R11 empty trigger: no error
        end

        // R10: reset in mid-frame with gate held high is ignored.
        keep = 12'hFFF;
        step(1'b1, 1'b0, 16'h1111);
        step(1'b1, 1'b0, 16'h2222);
        do_reset(1'b1, 1'b0);
        // R3: first frame after reset starts at channel 0.
        keep = 12'h800;
        for (int s = 0; s < NCH; s++) step(1'b1, 1'b0, DW'(16'h7000 + s));
        step(1'b0, 1'b1, '0);

        // R10: reset on a trigger cycle clears pending error.
        keep = 12'h001;
        for (int s = 0; s < 5; s++) step(1'b1, 1'b0, DW'(16'h5000 + s));
        do_reset(1'b0, 1'b1);
        step(1'b0, 1'b1, '0);  // R11 after reset, no error
        for (int s = 0; s < NCH; s++) step(1'b1, s == NCH - 1, DW'(16'h6000 + s));
        step(1'b0, 1'b1, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule